// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address for 4 KB pages. It reads two entries from memory: first a directory entry, then a table entry. The directory entry is found from a directory base register. The table entry is found from the frame that the directory entry names. The physical address is the table entry's frame number joined to the unchanged 12-bit page offset.

Along the way the walker checks presence and access rights at both levels. It reports a fault with its level and its cause. On a successful access it writes the accessed flag and, for a store, the dirty flag back into the entries it used. An entry is written only if one of those flags actually changes.

Only one translation is in progress at a time. The request, response and memory ports each use a valid/ready handshake. Every memory request, read or write, is answered by exactly one memory response pulse. A control write loads a new directory base. The new base is staged and only takes effect when no walk is running, which switches the whole address space.

Top module: `pgwalk_top`

## Requirements
- R1: After reset the block offers `req_ready`=1 and holds `rsp_valid`=0 and `mem_req_valid`=0. The directory base resets to 0.
- R2: Address forming:
  - The directory entry is read at base + 4·VA[31:22].
  - The table entry is read at {PDE[31:12],12'h000} + 4·VA[21:12].
  - A successful response gives `rsp_pa` = {PTE[31:12], VA[11:0]} with `rsp_fault`=0.
- R3: Entry flag positions: bit 0 present, bit 1 writable, bit 2 user (0 = supervisor only), bit 5 accessed, bit 6 dirty. A successful read sets bit 5 in both the directory entry and the table entry, and leaves bit 6 alone.
- R4: A successful write sets bits 5 and 6 in the table entry. It sets only bit 5 in the directory entry; the directory entry's bit 6 is never set by the walker.
- R5: An entry whose flags would not change is not written back. Every write-back the block does changes the stored word.
- R6: A directory entry with bit 0 = 0 ends the walk after one memory read. The response is a fault with `rsp_level`=0 (directory), `rsp_prot`=0 (not present) and `rsp_va` equal to the request address. No memory write is made.
- R7: A table entry with bit 0 = 0 gives a fault with `rsp_level`=1 (table) and `rsp_prot`=0. No entry is modified.
- R8: A write request whose directory or table entry has bit 1 = 0 gives a fault with `rsp_prot`=1 (protection). The directory is checked first, so `rsp_level` names the first level that denies the write. No entry is modified.
- R9: A user-mode request whose directory or table entry has bit 2 = 0 gives a protection fault at the first denying level. A supervisor request to the same page succeeds.
- R10: A directory base written while a walk is running does not affect that walk; it applies from the next translation on.
- R11: Handshakes:
  - A response holds its value until it is accepted.
  - A memory request holds its address, data and direction until it is accepted.
  - `req_ready` stays low from acceptance of a request until its response is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_wr_en | input | 1 | Load a new directory base |
| base_wr_data | input | 32 | Directory base physical address |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | Access is a store |
| req_user | input | 1 | Access is from user mode |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_fault | output | 1 | Translation faulted |
| rsp_level | output | 1 | Fault level: 0 directory, 1 table |
| rsp_prot | output | 1 | Fault cause: 1 protection, 0 not present |
| rsp_va | output | 32 | Virtual address of this response |
| rsp_pa | output | 32 | Physical address (0 on a fault) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Memory byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Memory response (read data or write acknowledge) |
| mem_rsp_data | input | 32 | Read data |

## Verification
The bench builds the walker with its default flag positions: accessed at bit 5 and dirty at bit 6, with 12-bit offsets and 10-bit indices. These are the positions the requirements state, so the bench can compute every entry word and address itself.

With these values the bench places small directories at two distinct bases in a sparse memory model. Distinct directory slots then give independent fresh entries for each fault and permission case. The memory ready line can be toggled, so stalled memory requests and a base reload in the middle of a walk are both reachable.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  localparam int WORD_W = 32;
  localparam int OFF_W  = 12;
  localparam int IDX_W  = 10;
  localparam int ENT_LG = 2;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [3:0] {
    S_IDLE, S_DIR_RQ, S_DIR_WT, S_TBL_RQ, S_TBL_WT,
    S_DWB_RQ, S_DWB_WT, S_TWB_RQ, S_TWB_WT, S_RSP
  } walk_st_e;

  function automatic logic [IDX_W-1:0] dir_idx(word_t va);
    return va[WORD_W-1 -: IDX_W];
  endfunction

  function automatic logic [IDX_W-1:0] tbl_idx(word_t va);
    return va[OFF_W +: IDX_W];
  endfunction

  // table base plus entry size times index
  function automatic word_t slot_addr(word_t base, logic [IDX_W-1:0] idx);
    return base + (word_t'(idx) << ENT_LG);
  endfunction

  function automatic word_t frame_base(word_t ent);
    return {ent[WORD_W-1:OFF_W], {OFF_W{1'b0}}};
  endfunction

  function automatic word_t join_pa(word_t pte, word_t va);
    return {pte[WORD_W-1:OFF_W], va[OFF_W-1:0]};
  endfunction

  function automatic word_t mark_entry(word_t ent, logic set_d, int a_pos, int d_pos);
    word_t r;
    r = ent;
    r[a_pos] = 1'b1;
    if (set_d) r[d_pos] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/pgwalk_perm.sv
module pgwalk_perm (
  input  logic present_b,
  input  logic write_b,
  input  logic user_b,
  input  logic is_write,
  input  logic is_user,
  output logic present,
  output logic allowed
);
  always_comb begin
    present = present_b;
    allowed = !(is_write && !write_b) && !(is_user && !user_b);
  end
endmodule

// File: rtl/pgwalk_base.sv
module pgwalk_base
  import pgwalk_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  word_t wr_data,
  input  logic  apply,
  output word_t base,
  output logic  pending
);
  word_t staged;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base    <= '0;
      staged  <= '0;
      pending <= 1'b0;
    end else begin
      if (apply) base <= staged;
      if (wr_en) begin
        staged  <= wr_data;
        pending <= 1'b1;
      end else if (apply) begin
        pending <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int P_BIT = 0,
  parameter int W_BIT = 1,
  parameter int U_BIT = 2,
  parameter int A_BIT = 5,
  parameter int D_BIT = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        base_wr_en,
  input  logic [31:0] base_wr_data,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_va,
  input  logic        req_write,
  input  logic        req_user,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic        rsp_fault,
  output logic        rsp_level,
  output logic        rsp_prot,
  output logic [31:0] rsp_va,
  output logic [31:0] rsp_pa,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic        mem_req_write,
  output logic [31:0] mem_req_addr,
  output logic [31:0] mem_req_wdata,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data
);
  walk_st_e st;
  word_t va_q, pde_q, pte_q, base_q;
  logic  wr_q, usr_q, fault_q, lvl_q, prot_q;
  logic  base_pend;

  // named internal events for the checker
  logic  walk_wrote;
  word_t wb_old;
  logic  req_fire, base_apply;

  word_t dir_addr, tbl_addr, pde_new, pte_new_rsp, pte_new_q;
  logic  ent_present, ent_allowed;

  assign base_apply = (st == S_IDLE) && base_pend;
  assign req_ready  = (st == S_IDLE) && !base_pend;
  assign req_fire   = req_valid && req_ready;

  pgwalk_base u_base (
    .clk(clk), .rst_n(rst_n), .wr_en(base_wr_en), .wr_data(base_wr_data),
    .apply(base_apply), .base(base_q), .pending(base_pend)
  );

  pgwalk_perm u_perm (
    .present_b(mem_rsp_data[P_BIT]), .write_b(mem_rsp_data[W_BIT]),
    .user_b(mem_rsp_data[U_BIT]), .is_write(wr_q), .is_user(usr_q),
    .present(ent_present), .allowed(ent_allowed)
  );

  always_comb begin
    dir_addr    = slot_addr(base_q, dir_idx(va_q));
    tbl_addr    = slot_addr(frame_base(pde_q), tbl_idx(va_q));
    pde_new     = mark_entry(pde_q, 1'b0, A_BIT, D_BIT);
    pte_new_rsp = mark_entry(mem_rsp_data, wr_q, A_BIT, D_BIT);
    pte_new_q   = mark_entry(pte_q, wr_q, A_BIT, D_BIT);
  end

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = dir_addr;
    mem_req_wdata = '0;
    wb_old        = '0;
    unique case (st)
      S_DIR_RQ: mem_req_valid = 1'b1;
      S_TBL_RQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = tbl_addr;
      end
      S_DWB_RQ: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_wdata = pde_new;
        wb_old        = pde_q;
      end
      S_TWB_RQ: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = tbl_addr;
        mem_req_wdata = pte_new_q;
        wb_old        = pte_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      va_q       <= '0;
      pde_q      <= '0;
      pte_q      <= '0;
      wr_q       <= 1'b0;
      usr_q      <= 1'b0;
      fault_q    <= 1'b0;
      lvl_q      <= 1'b0;
      prot_q     <= 1'b0;
      walk_wrote <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (req_fire) begin
          va_q       <= req_va;
          wr_q       <= req_write;
          usr_q      <= req_user;
          fault_q    <= 1'b0;
          lvl_q      <= 1'b0;
          prot_q     <= 1'b0;
          walk_wrote <= 1'b0;
          st         <= S_DIR_RQ;
        end
        S_DIR_RQ: if (mem_req_ready) st <= S_DIR_WT;
        S_DIR_WT: if (mem_rsp_valid) begin
          pde_q <= mem_rsp_data;
          if (!ent_present || !ent_allowed) begin
            fault_q <= 1'b1;
            lvl_q   <= 1'b0;
            prot_q  <= ent_present;
            st      <= S_RSP;
          end else begin
            st <= S_TBL_RQ;
          end
        end
        S_TBL_RQ: if (mem_req_ready) st <= S_TBL_WT;
        S_TBL_WT: if (mem_rsp_valid) begin
          pte_q <= mem_rsp_data;
          if (!ent_present || !ent_allowed) begin
            fault_q <= 1'b1;
            lvl_q   <= 1'b1;
            prot_q  <= ent_present;
            st      <= S_RSP;
          end else if (pde_new != pde_q) begin
            st <= S_DWB_RQ;
          end else if (pte_new_rsp != mem_rsp_data) begin
            st <= S_TWB_RQ;
          end else begin
            st <= S_RSP;
          end
        end
        S_DWB_RQ: if (mem_req_ready) begin
          walk_wrote <= 1'b1;
          st         <= S_DWB_WT;
        end
        S_DWB_WT: if (mem_rsp_valid) st <= (pte_new_q != pte_q) ? S_TWB_RQ : S_RSP;
        S_TWB_RQ: if (mem_req_ready) begin
          walk_wrote <= 1'b1;
          st         <= S_TWB_WT;
        end
        S_TWB_WT: if (mem_rsp_valid) st <= S_RSP;
        S_RSP:    if (rsp_ready) st <= S_IDLE;
        default:  st <= S_IDLE;
      endcase
    end
  end

  assign rsp_valid = (st == S_RSP);
  assign rsp_fault = fault_q;
  assign rsp_level = lvl_q;
  assign rsp_prot  = prot_q;
  assign rsp_va    = va_q;
  assign rsp_pa    = fault_q ? '0 : join_pa(pte_q, va_q);
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
  parameter int A_BIT = 5
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic        rsp_fault,
  input logic        rsp_level,
  input logic        rsp_prot,
  input logic [31:0] rsp_va,
  input logic [31:0] rsp_pa,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic        mem_req_write,
  input logic [31:0] mem_req_addr,
  input logic [31:0] mem_req_wdata,
  input logic        walk_wrote,
  input logic [31:0] wb_old
);
  // R11: a pending response holds its contents
  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_va)
      && $stable(rsp_fault) && $stable(rsp_level) && $stable(rsp_prot));

  // R11: a stalled memory request holds its contents
  a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata));

  // R11: no new request while a response waits
  a_r11_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R2: the page offset passes through
  a_r2_offset: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_pa[11:0] == rsp_va[11:0]);

  // R5: every write-back changes the stored entry
  a_r5_wb_changes: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> mem_req_wdata != wb_old);

  // R3 / R4: every write-back carries the accessed flag
  a_r3_wb_accessed: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> mem_req_wdata[A_BIT]);

  // R6 / R7 / R8: a faulting walk has written nothing
  a_r6_fault_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> !walk_wrote);
endmodule

bind pgwalk_top pgwalk_chk #(.A_BIT(A_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_fault(rsp_fault), .rsp_level(rsp_level),
  .rsp_prot(rsp_prot), .rsp_va(rsp_va), .rsp_pa(rsp_pa),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .walk_wrote(walk_wrote), .wb_old(wb_old)
);

// File: tb/pgwalk_top_tb.sv
module pgwalk_top_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic base_wr_en = 1'b0;
  logic [31:0] base_wr_data = '0;
  logic req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_va = '0;
  logic req_ready, rsp_valid, rsp_fault, rsp_level, rsp_prot;
  logic rsp_ready = 1'b0;
  logic [31:0] rsp_va, rsp_pa;
  logic mem_req_valid, mem_req_write;
  logic mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int tests = 0, fails = 0, wr_cnt = 0, rd_cnt = 0;
  logic stall_en = 1'b0;
  logic [31:0] mem [logic [31:0]];

  logic r_fault, r_level, r_prot;
  logic [31:0] r_va, r_pa;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgwalk_top u_dut (
    .clk(clk), .rst_n(rst_n), .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .req_write(req_write), .req_user(req_user), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_fault(rsp_fault), .rsp_level(rsp_level),
    .rsp_prot(rsp_prot), .rsp_va(rsp_va), .rsp_pa(rsp_pa),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [31:0] rd(logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  // sparse memory: one response pulse per accepted request
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        mem[mem_req_addr] = mem_req_wdata;
        wr_cnt++;
      end else begin
        rd_cnt++;
      end
      mem_rsp_data  <= rd(mem_req_addr);
      mem_rsp_valid <= 1'b1;
    end
    mem_req_ready <= stall_en ? ~mem_req_ready : 1'b1;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_base(logic [31:0] b);
    @(negedge clk);
    base_wr_en = 1'b1;
    base_wr_data = b;
    @(negedge clk);
    base_wr_en = 1'b0;
  endtask

  task automatic walk(logic [31:0] va, logic wr, logic usr, int hold);
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_write = wr; req_user = usr;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    r_fault = rsp_fault; r_level = rsp_level; r_prot = rsp_prot;
    r_va = rsp_va; r_pa = rsp_pa;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R11 rsp held valid", {31'b0, rsp_valid}, 32'h1);
      chk("R11 rsp pa stable", rsp_pa, r_pa);
      chk("R11 req_ready low while busy", {31'b0, req_ready}, 32'h0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 req_ready", {31'b0, req_ready}, 32'h1);
    chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'h0);
    chk("R1 mem_req_valid", {31'b0, mem_req_valid}, 32'h0);
  endtask

  task automatic t_read_map;
    int w0;
    w0 = wr_cnt;
    walk(32'h1234_5678, 1'b0, 1'b0, 0);
    chk("R2 no fault", {31'b0, r_fault}, 32'h0);
    chk("R2 pa", r_pa, 32'h6789_a678);
    chk("R3 pde accessed", rd(32'h0001_0120), 32'h0002_0027);
    chk("R3 pte accessed", rd(32'h0002_0d14), 32'h6789_a027);
    chk("R3 two write-backs", wr_cnt - w0, 2);
  endtask

  task automatic t_write_dirty;
    int w0;
    w0 = wr_cnt;
    walk(32'h1234_5abc, 1'b1, 1'b0, 0);
    chk("R4 pa", r_pa, 32'h6789_aabc);
    chk("R4 pte dirty", rd(32'h0002_0d14), 32'h6789_a067);
    chk("R4 pde no dirty", rd(32'h0001_0120), 32'h0002_0027);
    chk("R5 only pte written", wr_cnt - w0, 1);
  endtask

  task automatic t_no_wb;
    int w0;
    w0 = wr_cnt;
    walk(32'h1234_5004, 1'b1, 1'b0, 0);
    chk("R5 pa", r_pa, 32'h6789_a004);
    chk("R5 no write-back", wr_cnt - w0, 0);
  endtask

  task automatic t_dir_np;
    int w0, r0;
    w0 = wr_cnt; r0 = rd_cnt;
    walk(32'h4000_0123, 1'b0, 1'b0, 0);
    chk("R6 fault", {31'b0, r_fault}, 32'h1);
    chk("R6 level dir", {31'b0, r_level}, 32'h0);
    chk("R6 cause not-present", {31'b0, r_prot}, 32'h0);
    chk("R6 va", r_va, 32'h4000_0123);
    chk("R6 one read", rd_cnt - r0, 1);
    chk("R6 no write", wr_cnt - w0, 0);
  endtask

  task automatic t_tbl_np;
    int w0;
    w0 = wr_cnt;
    walk(32'h1240_0000, 1'b0, 1'b0, 0);
    chk("R7 fault", {31'b0, r_fault}, 32'h1);
    chk("R7 level table", {31'b0, r_level}, 32'h1);
    chk("R7 cause not-present", {31'b0, r_prot}, 32'h0);
    chk("R7 pde untouched", rd(32'h0001_0124), 32'h0003_0007);
    chk("R7 no write", wr_cnt - w0, 0);
  endtask

  task automatic t_prot_write;
    int w0;
    w0 = wr_cnt;
    walk(32'h1280_0010, 1'b1, 1'b0, 0);
    chk("R8 dir fault", {29'b0, r_fault, r_level, r_prot}, 32'h5);
    walk(32'h12c0_0000, 1'b1, 1'b0, 0);
    chk("R8 tbl fault", {29'b0, r_fault, r_level, r_prot}, 32'h7);
    chk("R8 no write", wr_cnt - w0, 0);
    chk("R8 pte untouched", rd(32'h0005_0000), 32'h2222_2005);
    walk(32'h1280_0010, 1'b0, 1'b0, 0);
    chk("R8 read allowed", r_pa, 32'h1111_1010);
  endtask

  task automatic t_prot_user;
    walk(32'h1300_0000, 1'b0, 1'b1, 0);
    chk("R9 dir user fault", {29'b0, r_fault, r_level, r_prot}, 32'h5);
    walk(32'h1340_0000, 1'b0, 1'b1, 0);
    chk("R9 tbl user fault", {29'b0, r_fault, r_level, r_prot}, 32'h7);
    walk(32'h1300_0000, 1'b0, 1'b0, 0);
    chk("R9 supervisor ok", {r_pa[31:1], r_fault}, 32'h3333_3000);
    walk(32'h1340_0000, 1'b1, 1'b0, 0);
    chk("R9 supervisor write ok", r_pa, 32'h4444_4000);
  endtask

  task automatic t_base_switch;
    set_base(32'h0008_0000);
    stall_en = 1'b1;
    fork
      walk(32'h1234_5678, 1'b0, 1'b0, 0);
      begin
        repeat (3) @(negedge clk);
        set_base(32'h0001_0000);
      end
    join
    chk("R10 walk uses old base", r_pa, 32'h5555_5678);
    walk(32'h1234_5678, 1'b0, 1'b0, 0);
    chk("R10 next walk uses new base", r_pa, 32'h6789_a678);
    stall_en = 1'b0;
  endtask

  task automatic t_hold;
    walk(32'h1234_5fff, 1'b0, 1'b0, 3);
    chk("R11 pa after hold", r_pa, 32'h6789_afff);
  endtask

  initial begin
    mem[32'h0001_0120] = 32'h0002_0007;
    mem[32'h0002_0d14] = 32'h6789_a007;
    mem[32'h0001_0124] = 32'h0003_0007;
    mem[32'h0001_0128] = 32'h0004_0005;
    mem[32'h0004_0000] = 32'h1111_1007;
    mem[32'h0001_012c] = 32'h0005_0007;
    mem[32'h0005_0000] = 32'h2222_2005;
    mem[32'h0001_0130] = 32'h0006_0003;
    mem[32'h0006_0000] = 32'h3333_3001;
    mem[32'h0001_0134] = 32'h0007_0007;
    mem[32'h0007_0000] = 32'h4444_4003;
    mem[32'h0008_0120] = 32'h0009_0007;
    mem[32'h0009_0d14] = 32'h5555_5007;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    set_base(32'h0001_0000);
    t_read_map;
    t_write_dirty;
    t_no_wb;
    t_dir_np;
    t_tbl_np;
    t_prot_write;
    t_prot_user;
    t_base_switch;
    t_hold;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule